// File: doc/BRIEF.md
# Operand Bypass and Load Hazard Controller

This controller sits beside the decode and execute stages of a five-stage in-order integer pipeline. Operands are read in the second stage and results are written back in the fifth, so the only hazard it has to handle is a read that follows a write. Each cycle it looks at the source register numbers of the instruction in execute and of the one in decode. It compares them with the destinations still in flight in the two later latches. It then drives the select codes of the two ALU operand muxes and of the store-data mux, which sits in the memory stage. Register 0 always reads as zero, so it never takes part in a match.

An ALU result can be bypassed from either later latch, so dependent ALU instructions run back to back. A load result is not known until the end of the memory stage. When the instruction right after a load needs the loaded value as an ALU operand, the controller raises `stall_o` and `bubble_o` together for that cycle. The pipeline then holds PC and the fetch/decode latch and clears the control bits entering execute. Once the load has moved on, the dependency is served from the writeback latch. A store that needs a just-loaded register only as its data does not stall: the data is replaced in the memory stage from the writeback latch.

All outputs depend combinationally on the current stage fields. `clk` and `rst_n` serve only the embedded property checks. No pin carries streamed data, so there is no valid/ready handshake.

Top module: `hazard_bypass_ctrl`

## Requirements
- R1: `alu_a_sel_o` is 2'b10 (take the memory-stage latch) when `ex_rs1_i` is nonzero, `mem_we_i` is 1, `mem_is_load_i` is 0 and `mem_rd_i` equals `ex_rs1_i`; this takes priority over a writeback match.
- R2: Otherwise `alu_a_sel_o` is 2'b01 (take the writeback latch) when `ex_rs1_i` is nonzero, `wb_we_i` is 1 and `wb_rd_i` equals `ex_rs1_i`.
- R3: Otherwise `alu_a_sel_o` is 2'b00 (register file value); code 2'b11 never appears.
- R4: `alu_b_sel_o` follows the rules of R1 to R3 with `ex_rs2_i` as the source.
- R5: A source register number of 0 never selects a bypass path on any of the three selects.
- R6: `stall_o` is 1 exactly when `ex_is_load_i`, `ex_we_i` are 1 and `ex_rd_i` is nonzero, and either (`id_use_rs1_i` is 1 and `id_rs1_i` equals `ex_rd_i`) or (`id_use_rs2_i` is 1, `id_is_store_i` is 0 and `id_rs2_i` equals `ex_rd_i`).
- R7: `bubble_o` equals `stall_o` in every cycle.
- R8: `st_data_fwd_o` is 1 exactly when `mem_is_store_i`, `wb_we_i` are 1, `mem_rs2_i` is nonzero and `wb_rd_i` equals `mem_rs2_i`; a store needing a loaded register only as data never stalls.
- R9: A load held in the memory-stage latch is never a bypass source; a matching writeback destination is used instead, else the register file.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for property checks |
| rst_n | input | 1 | Active-low reset, disables property checks |
| id_rs1_i | input | REG_W | First source of decode instruction |
| id_rs2_i | input | REG_W | Second source of decode instruction |
| id_use_rs1_i | input | 1 | Decode instruction reads first source |
| id_use_rs2_i | input | 1 | Decode instruction reads second source |
| id_is_store_i | input | 1 | Decode instruction is a store (second source is store data) |
| ex_rs1_i | input | REG_W | First source of execute instruction |
| ex_rs2_i | input | REG_W | Second source of execute instruction |
| ex_rd_i | input | REG_W | Destination of execute instruction |
| ex_we_i | input | 1 | Execute instruction writes a register |
| ex_is_load_i | input | 1 | Execute instruction is a load |
| mem_rs2_i | input | REG_W | Store-data register of memory-stage instruction |
| mem_is_store_i | input | 1 | Memory-stage instruction is a store |
| mem_rd_i | input | REG_W | Destination in memory-stage latch |
| mem_we_i | input | 1 | Memory-stage latch writes a register |
| mem_is_load_i | input | 1 | Memory-stage latch holds a load |
| wb_rd_i | input | REG_W | Destination in writeback latch |
| wb_we_i | input | 1 | Writeback latch writes a register |
| alu_a_sel_o | output | 2 | First ALU operand mux select |
| alu_b_sel_o | output | 2 | Second ALU operand mux select |
| st_data_fwd_o | output | 1 | Replace store data with writeback value |
| stall_o | output | 1 | Hold PC and fetch/decode latch |
| bubble_o | output | 1 | Clear control bits entering execute |

## Verification
Every cycle, the embedded properties check several rules. The selects are legal codes, register 0 is never bypassed, and a load in the memory latch is never a source. Stall and bubble always agree, and a stall implies a load in execute. Store-data replacement happens only for a store, and a data-only dependency of a store never stalls. Whether the chosen path is the right one needs the bench. This covers the priority of the younger latch when both match, the exact set of stall conditions, and the load-then-store sequence. The bench checks these against its own model under random and directed stage contents.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } src_sel_t;
endpackage

// File: rtl/hbc_operand_sel.sv
module hbc_operand_sel
  import hbc_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_we_i,
  input  logic             mem_is_load_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_we_i,
  output src_sel_t         sel_o
);
  logic src_nz, hit_mem, hit_wb;

  assign src_nz  = (src_i != '0);
  // a load in the memory latch has no data yet
  assign hit_mem = src_nz && mem_we_i && !mem_is_load_i && (mem_rd_i == src_i);
  assign hit_wb  = src_nz && wb_we_i && (wb_rd_i == src_i);

  always_comb begin
    if (hit_mem)     sel_o = SRC_MEM;
    else if (hit_wb) sel_o = SRC_WB;
    else             sel_o = SRC_RF;
  end

  assert_zero_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == '0) |-> (sel_o == SRC_RF));
  assert_legal_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_o));
  assert_no_load_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_is_load_i |-> (sel_o != SRC_MEM));
  assert_wb_needs_we_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o == SRC_WB) |-> (wb_we_i && wb_rd_i == src_i));
endmodule

// File: rtl/hbc_load_interlock.sv
module hbc_load_interlock #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] id_rs1_i,
  input  logic [REG_W-1:0] id_rs2_i,
  input  logic             id_use_rs1_i,
  input  logic             id_use_rs2_i,
  input  logic             id_is_store_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_we_i,
  input  logic             ex_is_load_i,
  output logic             stall_o,
  output logic             bubble_o
);
  logic load_live, dep_a, dep_b;

  assign load_live = ex_is_load_i && ex_we_i && (ex_rd_i != '0);
  assign dep_a     = id_use_rs1_i && (id_rs1_i == ex_rd_i);
  // store data is patched later in the memory stage, so it does not stall
  assign dep_b     = id_use_rs2_i && !id_is_store_i && (id_rs2_i == ex_rd_i);
  assign stall_o   = load_live && (dep_a || dep_b);
  assign bubble_o  = stall_o;

  assert_stall_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (ex_is_load_i && ex_rd_i != '0));
  assert_bubble_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_o == stall_o);
  assert_store_data_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (id_is_store_i && !id_use_rs1_i) |-> !stall_o);
endmodule

// File: rtl/hbc_store_data.sv
module hbc_store_data #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] mem_rs2_i,
  input  logic             mem_is_store_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_we_i,
  output logic             fwd_o
);
  assign fwd_o = mem_is_store_i && wb_we_i && (mem_rs2_i != '0) && (wb_rd_i == mem_rs2_i);

  assert_store_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_o |-> mem_is_store_i);
  assert_store_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rs2_i == '0) |-> !fwd_o);
endmodule

// File: rtl/hazard_bypass_ctrl.sv
module hazard_bypass_ctrl
  import hbc_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] id_rs1_i,
  input  logic [REG_W-1:0] id_rs2_i,
  input  logic             id_use_rs1_i,
  input  logic             id_use_rs2_i,
  input  logic             id_is_store_i,
  input  logic [REG_W-1:0] ex_rs1_i,
  input  logic [REG_W-1:0] ex_rs2_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_we_i,
  input  logic             ex_is_load_i,
  input  logic [REG_W-1:0] mem_rs2_i,
  input  logic             mem_is_store_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_we_i,
  input  logic             mem_is_load_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_we_i,
  output logic [1:0]       alu_a_sel_o,
  output logic [1:0]       alu_b_sel_o,
  output logic             st_data_fwd_o,
  output logic             stall_o,
  output logic             bubble_o
);
  localparam int N_OPS = 2;

  logic [REG_W-1:0] op_src [N_OPS];
  src_sel_t         op_sel [N_OPS];

  assign op_src[0] = ex_rs1_i;
  assign op_src[1] = ex_rs2_i;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    hbc_operand_sel #(.REG_W(REG_W)) u_sel (
      .clk          (clk),
      .rst_n        (rst_n),
      .src_i        (op_src[g]),
      .mem_rd_i     (mem_rd_i),
      .mem_we_i     (mem_we_i),
      .mem_is_load_i(mem_is_load_i),
      .wb_rd_i      (wb_rd_i),
      .wb_we_i      (wb_we_i),
      .sel_o        (op_sel[g])
    );
  end

  assign alu_a_sel_o = op_sel[0];
  assign alu_b_sel_o = op_sel[1];

  hbc_load_interlock #(.REG_W(REG_W)) u_ilk (
    .clk          (clk),
    .rst_n        (rst_n),
    .id_rs1_i     (id_rs1_i),
    .id_rs2_i     (id_rs2_i),
    .id_use_rs1_i (id_use_rs1_i),
    .id_use_rs2_i (id_use_rs2_i),
    .id_is_store_i(id_is_store_i),
    .ex_rd_i      (ex_rd_i),
    .ex_we_i      (ex_we_i),
    .ex_is_load_i (ex_is_load_i),
    .stall_o      (stall_o),
    .bubble_o     (bubble_o)
  );

  hbc_store_data #(.REG_W(REG_W)) u_st (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_rs2_i     (mem_rs2_i),
    .mem_is_store_i(mem_is_store_i),
    .wb_rd_i       (wb_rd_i),
    .wb_we_i       (wb_we_i),
    .fwd_o         (st_data_fwd_o)
  );

  assert_youngest_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_a_sel_o == 2'b01) |-> !(mem_we_i && !mem_is_load_i && mem_rd_i == ex_rs1_i));
  assert_b_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs2_i == '0) |-> (alu_b_sel_o == 2'b00));
endmodule

// File: tb/hazard_bypass_ctrl_bench.sv
module hazard_bypass_ctrl_bench;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [REG_W-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rs2, mem_rd, wb_rd;
  logic id_u1, id_u2, id_st, ex_we, ex_ld, mem_st, mem_we, mem_ld, wb_we;
  logic [1:0] a_sel, b_sel;
  logic st_fwd, stall, bubble;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hazard_bypass_ctrl #(.REG_W(REG_W)) u_hazard_bypass_ctrl (
    .clk(clk), .rst_n(rst_n),
    .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .id_use_rs1_i(id_u1), .id_use_rs2_i(id_u2),
    .id_is_store_i(id_st), .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .ex_rd_i(ex_rd),
    .ex_we_i(ex_we), .ex_is_load_i(ex_ld), .mem_rs2_i(mem_rs2), .mem_is_store_i(mem_st),
    .mem_rd_i(mem_rd), .mem_we_i(mem_we), .mem_is_load_i(mem_ld), .wb_rd_i(wb_rd),
    .wb_we_i(wb_we), .alu_a_sel_o(a_sel), .alu_b_sel_o(b_sel), .st_data_fwd_o(st_fwd),
    .stall_o(stall), .bubble_o(bubble)
  );

  function automatic logic [1:0] exp_sel(logic [REG_W-1:0] s);
    if (s != 0 && mem_we && !mem_ld && mem_rd == s) return 2'b10;
    if (s != 0 && wb_we && wb_rd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic exp_stall();
    if (!(ex_ld && ex_we && ex_rd != 0)) return 1'b0;
    return (id_u1 && id_rs1 == ex_rd) || (id_u2 && !id_st && id_rs2 == ex_rd);
  endfunction

  function automatic logic exp_st();
    return mem_st && wb_we && mem_rs2 != 0 && wb_rd == mem_rs2;
  endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_all();
    {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rs2, mem_rd, wb_rd} = '0;
    {id_u1, id_u2, id_st, ex_we, ex_ld, mem_st, mem_we, mem_ld, wb_we} = '0;
  endtask

  task automatic check_all();
    #1;
    check("R1 R2 R3 select A", a_sel, exp_sel(ex_rs1));
    check("R4 select B", b_sel, exp_sel(ex_rs2));
    check("R6 stall", stall, exp_stall());
    check("R7 bubble", bubble, exp_stall());
    check("R8 store data", st_fwd, exp_st());
  endtask

  initial begin
    void'($urandom(32'h5EED_2024));
    clear_all();
    repeat (3) @(posedge clk);
    #1;
    check("reset R3 A", a_sel, 0);
    check("reset R6 stall", stall, 0);
    rst_n = 1'b1;

    // R1: both latches match, younger wins
    @(negedge clk); clear_all();
    ex_rs1 = 5'd3; mem_rd = 5'd3; mem_we = 1; wb_rd = 5'd3; wb_we = 1;
    #1; check("R1 priority", a_sel, 2'b10);
    // R2: only writeback matches
    @(negedge clk); mem_rd = 5'd4;
    #1; check("R2 wb path", a_sel, 2'b01);
    // R5: register 0 never bypassed
    @(negedge clk); clear_all();
    ex_rs1 = 0; ex_rs2 = 0; mem_rd = 0; mem_we = 1; wb_rd = 0; wb_we = 1;
    mem_st = 1; mem_rs2 = 0;
    #1; check("R5 A zero", a_sel, 0); check("R5 B zero", b_sel, 0); check("R5 store zero", st_fwd, 0);
    // R9: load in memory latch skipped, writeback used
    @(negedge clk); clear_all();
    ex_rs2 = 5'd7; mem_rd = 5'd7; mem_we = 1; mem_ld = 1; wb_rd = 5'd7; wb_we = 1;
    #1; check("R9 load skip to wb", b_sel, 2'b01);
    @(negedge clk); wb_we = 0;
    #1; check("R9 load skip to rf", b_sel, 2'b00);
    // R6/R7: load then dependent ALU use
    @(negedge clk); clear_all();
    ex_ld = 1; ex_we = 1; ex_rd = 5'd9; id_u1 = 1; id_rs1 = 5'd9;
    #1; check("R6 load-use stall", stall, 1); check("R7 bubble", bubble, 1);
    // load to r0 does not stall
    @(negedge clk); ex_rd = 0; id_rs1 = 0;
    #1; check("R6 r0 load", stall, 0);
    // R8: store whose data is the loaded register: no stall, patched next stage
    @(negedge clk); clear_all();
    ex_ld = 1; ex_we = 1; ex_rd = 5'd6; id_st = 1; id_u1 = 1; id_rs1 = 5'd2;
    id_u2 = 1; id_rs2 = 5'd6;
    #1; check("R8 store no stall", stall, 0);
    @(negedge clk); clear_all();
    mem_st = 1; mem_rs2 = 5'd6; wb_rd = 5'd6; wb_we = 1;
    #1; check("R8 store patch", st_fwd, 1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      id_rs1 = REG_W'($urandom % 4); id_rs2 = REG_W'($urandom % 4);
      ex_rs1 = REG_W'($urandom % 4); ex_rs2 = REG_W'($urandom % 4);
      ex_rd = REG_W'($urandom % 4); mem_rs2 = REG_W'($urandom % 4);
      mem_rd = REG_W'($urandom % 4); wb_rd = REG_W'($urandom % 4);
      {id_u1, id_u2, id_st, ex_we, ex_ld, mem_st, mem_we, mem_ld, wb_we} = 9'($urandom);
      check_all();
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog R1 actual=hang expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule